// File: doc/BRIEF.md
# I2C Target with Indexed Byte Store

This block is a target (slave) on a two-wire I2C bus that serves a small bank of byte-wide storage entries. Both bus lines are brought into the local clock domain through flop synchronizers. The block detects start and stop conditions itself and only ever pulls the data line low, through an open-drain enable. A transaction opens with an address byte whose upper seven bits must equal the build-time device address. A location byte follows; its low bits pick the entry. The low bit of the address byte then fixes the direction for the rest of the transaction.

On a write the target stores one data byte at the chosen entry and reports the store on a one-cycle strobe to local logic. On a read the target sends the entry's contents straight after the location byte has been acknowledged, with no repeated start. It keeps sending the following entries for as long as the controller acknowledges. Local logic can read any entry at any time through a separate combinational port. General call, 10-bit addressing and clock stretching are not part of the block.

Top module: `i2c_idx_target`

## Requirements
- R1: A falling data line while the synchronized clock line is high (start) clears the bit count and makes the target expect an address byte, even when a transfer is in progress; a transfer cut short this way stores nothing.
- R2: A rising data line while the clock line is high (stop) returns the target to idle with the data line released; a byte sent after a stop without a new start is not acknowledged.
- R3: When bits 7..1 of the first byte after a start equal DEV_ADDR (default 7'h2A), the target pulls the data line low for the ninth clock. On any other value it never pulls the data line low until the next start, and it stores nothing.
- R4: The second byte is taken as a location and acknowledged on its ninth clock; its low log2(DEPTH) bits select the entry, so the location wraps modulo DEPTH (16 by default).
- R5: With bit 0 of the first byte at 0 (write), the third byte is stored at the selected entry and acknowledged; any further byte before a stop is neither acknowledged nor stored.
- R6: With bit 0 of the first byte at 1 (read), the target drives the selected entry, most significant bit first, in the eight clocks that follow the location acknowledge, and it releases the data line for the ninth clock.
- R7: A low data line in that ninth clock (controller acknowledge) makes the target send the next entry, wrapping from DEPTH-1 to 0. A high data line (no acknowledge) ends its transmit role, and it keeps the data line released until the next start or stop.
- R8: Each stored byte raises wr_evt_o for exactly one clock, with wr_evt_idx_o and wr_evt_data_o giving the entry and the byte.
- R9: After reset every entry reads 0 on the local port and sda_oe_o is 0; usr_rd_data_o always shows the entry selected by usr_rd_idx_i.
- R10: The data-line enable changes only after a synchronized falling edge of the clock line (or at a start or stop), never while the clock line is high in the middle of a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| usr_rd_idx_i | input | log2(DEPTH) | Entry selected for the local read |
| usr_rd_data_o | output | 8 | Contents of the selected entry |
| wr_evt_o | output | 1 | One-clock strobe for each byte stored from the bus |
| wr_evt_idx_o | output | log2(DEPTH) | Entry written, valid with the strobe |
| wr_evt_data_o | output | 8 | Byte written, valid with the strobe |

## Verification
Every entry is written and then read back over the bus with a distinct arithmetic value, and the stored result is also checked on the local port. This separates index decode faults from data path faults. Device addresses that differ from DEV_ADDR in exactly one bit show whether each address bit is compared. Location values above DEPTH and a sequential read that crosses the last entry exercise the wrap. A restart in the middle of an address, a restart in the middle of a data byte, a stop before the data byte, an extra write byte and a sequential read ended by no-acknowledge each show whether the transfer is aborted, or the target released, at the right point.

// File: rtl/i2ct_pkg.sv
// Package: shared state encoding and byte width for the I2C indexed target.
// Assumes nothing beyond standard SystemVerilog.
package i2ct_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LOC,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_MACK,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2ct_line_sync.sv
// Module: multi-flop synchronizer for one asynchronous bus line.
// Assumes STAGES >= 2; resets to RST_VAL (idle bus level).
module i2ct_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    // Shift the raw line level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], async_i};
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/i2ct_bus_events.sv
// Module: turns synchronized clock/data levels into single-cycle bus events.
// Assumes both inputs come through synchronizers of equal depth.
module i2ct_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise_o = !scl_q &&  scl_s;
    assign scl_fall_o =  scl_q && !scl_s;
    assign start_o    =  scl_q &&  scl_s &&  sda_q && !sda_s;
    assign stop_o     =  scl_q &&  scl_s && !sda_q &&  sda_s;
endmodule

// File: rtl/i2ct_store.sv
// Module: DEPTH entries of one byte, one write port, two combinational reads.
// Assumes DEPTH is a power of two so indices wrap naturally.
module i2ct_store #(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [7:0]       wdata_i,
    input  logic [IDX_W-1:0] bus_idx_i,
    output logic [7:0]       bus_data_o,
    input  logic [IDX_W-1:0] usr_idx_i,
    output logic [7:0]       usr_data_o
);
    logic [DEPTH*8-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [7:0] q;

        // Hold one entry; load it when the write index matches.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  q <= 8'h00;
            else if (we_i && widx_i == IDX_W'(g))        q <= wdata_i;
        end

        assign flat[g*8 +: 8] = q;

        // R5: a write to this entry holds the written byte on the next cycle
        assert_entry_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && widx_i == IDX_W'(g)) |=> (q == $past(wdata_i)));
    end

    assign bus_data_o = flat[{bus_idx_i, 3'b000} +: 8];
    assign usr_data_o = flat[{usr_idx_i, 3'b000} +: 8];
endmodule

// File: rtl/i2ct_fsm.sv
// Module: byte-level protocol engine of the target: address match, location,
// single-byte write, sequential read with controller acknowledge.
// Assumes single-cycle event inputs from i2ct_bus_events and a
// combinational read of the entry at loc_o.
module i2ct_fsm
    import i2ct_pkg::*;
#(
    parameter  logic [6:0] DEV_ADDR = 7'h2A,
    parameter  int         DEPTH    = 16,
    localparam int         IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             sda_s_i,
    input  logic [7:0]       rd_data_i,
    output logic [IDX_W-1:0] loc_o,
    output logic             sda_oe_o,
    output logic             we_o,
    output logic [7:0]       wdata_o
);
    tgt_state_e       state;
    tgt_state_e       after;
    logic [2:0]       bitcnt;
    logic [7:0]       shreg;
    logic [6:0]       txreg;
    logic             byte_full;
    logic             rw;
    logic [IDX_W-1:0] loc;
    logic             oe;
    logic             we;
    logic [7:0]       wdata;

    // Advance the protocol on synchronized bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after     <= ST_IDLE;
            bitcnt    <= 3'd0;
            shreg     <= 8'h00;
            txreg     <= 7'h00;
            byte_full <= 1'b0;
            rw        <= 1'b0;
            loc       <= '0;
            oe        <= 1'b0;
            we        <= 1'b0;
            wdata     <= 8'h00;
        end else begin
            we <= 1'b0;
            if (start_i) begin
                state     <= ST_ADDR;
                bitcnt    <= 3'd0;
                byte_full <= 1'b0;
                oe        <= 1'b0;
            end else if (stop_i) begin
                state     <= ST_IDLE;
                byte_full <= 1'b0;
                oe        <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_LOC, ST_WDATA: begin
                        if (scl_rise_i && !byte_full) begin
                            shreg <= {shreg[6:0], sda_s_i};
                            if (bitcnt == 3'd7) begin
                                byte_full <= 1'b1;
                                bitcnt    <= 3'd0;
                            end else begin
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end else if (scl_fall_i && byte_full) begin
                            byte_full <= 1'b0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    oe    <= 1'b1;
                                    rw    <= shreg[0];
                                    after <= ST_LOC;
                                    state <= ST_ACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_LOC) begin
                                loc   <= shreg[IDX_W-1:0];
                                oe    <= 1'b1;
                                after <= rw ? ST_RDATA : ST_WDATA;
                                state <= ST_ACK;
                            end else begin
                                we    <= 1'b1;
                                wdata <= shreg;
                                oe    <= 1'b1;
                                after <= ST_SKIP;
                                state <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall_i) begin
                            bitcnt <= 3'd0;
                            state  <= after;
                            if (after == ST_RDATA) begin
                                txreg <= rd_data_i[6:0];
                                oe    <= !rd_data_i[7];
                            end else begin
                                oe <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise_i && !byte_full) begin
                            if (bitcnt == 3'd7) begin
                                byte_full <= 1'b1;
                                bitcnt    <= 3'd0;
                            end else begin
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end else if (scl_fall_i) begin
                            if (byte_full) begin
                                byte_full <= 1'b0;
                                oe        <= 1'b0;
                                state     <= ST_MACK;
                            end else begin
                                oe    <= !txreg[6];
                                txreg <= {txreg[5:0], 1'b0};
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise_i) begin
                            if (!sda_s_i) begin
                                loc   <= loc + IDX_W'(1);
                                after <= ST_RDATA;
                                state <= ST_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign loc_o    = loc;
    assign sda_oe_o = oe;
    assign we_o     = we;
    assign wdata_o  = wdata;

    // R1: a start always leads to address listening with the line released
    assert_start_listen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state == ST_ADDR && !oe));

    // R2: a stop returns to idle with the line released
    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (state == ST_IDLE && !oe));

    // R3: while ignoring traffic the data line is never pulled
    assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !oe);

    // R8: the write strobe lasts a single cycle
    assert_wr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

    // R10: the enable moves only after a clock fall, start or stop
    assert_oe_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (oe != $past(oe)) |-> $past(scl_fall_i || start_i || stop_i));
endmodule

// File: rtl/i2c_idx_target.sv
// Module: top of the I2C target serving DEPTH byte entries.
// Assumes an external pull-up on the data line; sda_oe_o drives it low.
module i2c_idx_target #(
    parameter  logic [6:0] DEV_ADDR    = 7'h2A,
    parameter  int         DEPTH       = 16,
    parameter  int         SYNC_STAGES = 2,
    localparam int         IDX_W       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [IDX_W-1:0] usr_rd_idx_i,
    output logic [7:0]       usr_rd_data_o,
    output logic             wr_evt_o,
    output logic [IDX_W-1:0] wr_evt_idx_o,
    output logic [7:0]       wr_evt_data_o
);
    logic             scl_s;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start;
    logic             stop;
    logic [IDX_W-1:0] loc;
    logic [7:0]       rd_data;
    logic             we;
    logic [7:0]       wdata;

    i2ct_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .async_i(scl_i), .sync_o(scl_s));

    i2ct_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sda_i), .sync_o(sda_s));

    i2ct_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start), .stop_o(stop));

    i2ct_fsm #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start), .stop_i(stop), .sda_s_i(sda_s),
        .rd_data_i(rd_data), .loc_o(loc), .sda_oe_o(sda_oe_o),
        .we_o(we), .wdata_o(wdata));

    i2ct_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_i(we), .widx_i(loc), .wdata_i(wdata),
        .bus_idx_i(loc), .bus_data_o(rd_data),
        .usr_idx_i(usr_rd_idx_i), .usr_data_o(usr_rd_data_o));

    assign wr_evt_o      = we;
    assign wr_evt_idx_o  = loc;
    assign wr_evt_data_o = wdata;
endmodule

// File: tb/tb_i2c_idx_target.sv
module tb_i2c_idx_target;
    localparam logic [6:0] DEV = 7'h2A;
    localparam int         DEPTH = 16;
    localparam int         IW = 4;
    localparam int         Q = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_line;
    logic          dut_oe;
    logic [IW-1:0] usr_idx = '0;
    logic [7:0]    usr_data;
    logic          wr_evt;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int evt_cnt = 0;
    int evt_long = 0;
    int oe_bad = 0;
    int oe_hi = 0;
    logic evt_prev = 1'b0;
    logic oe_prev = 1'b0;
    logic [IW-1:0] evt_idx = '0;
    logic [7:0] evt_data = 8'h00;
    logic [7:0] model [DEPTH];
    bit done = 1'b0;

    assign sda_line = sda_m & ~dut_oe;

    always #5 clk = ~clk;

    i2c_idx_target #(.DEV_ADDR(DEV), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(dut_oe), .usr_rd_idx_i(usr_idx), .usr_rd_data_o(usr_data),
        .wr_evt_o(wr_evt), .wr_evt_idx_o(wr_idx), .wr_evt_data_o(wr_data));

    // Observe write strobes and data-line enable changes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_evt) begin
                evt_cnt++;
                evt_idx  = wr_idx;
                evt_data = wr_data;
                if (evt_prev) evt_long++;
            end
            if (dut_oe != oe_prev && scl_m) oe_bad++;
            if (dut_oe) oe_hi++;
        end
        evt_prev = wr_evt;
        oe_prev  = dut_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic usr_read(input int idx, output logic [7:0] v);
        usr_idx = IW'(idx);
        tick(1);
        v = usr_data;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29 + 7) ^ (i << 4));
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] v;
        int         e0;
        int         h0;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R9: reset state
        check("R9", 32'(dut_oe), 0, "oe after reset");
        for (int i = 0; i < DEPTH; i++) begin
            usr_read(i, v);
            check("R9", 32'(v), 0, "entry after reset");
            model[i] = 8'h00;
        end

        // R3 R4 R5 R8 R9: write sweep over every entry
        for (int i = 0; i < DEPTH; i++) begin
            e0 = evt_cnt;
            bus_start();
            send_byte({DEV, 1'b0}, ack); check("R3", 32'(ack), 1, "address ack");
            send_byte(8'(i), ack);       check("R4", 32'(ack), 1, "location ack");
            send_byte(pat(i), ack);      check("R5", 32'(ack), 1, "data ack");
            bus_stop();
            model[i] = pat(i);
            check("R8", 32'(evt_cnt - e0), 1, "one strobe per write");
            check("R8", 32'(evt_idx), 32'(i), "strobe index");
            check("R8", 32'(evt_data), 32'(pat(i)), "strobe data");
            usr_read(i, v);
            check("R9", 32'(v), 32'(pat(i)), "local read after write");
        end

        // R6: single-byte read sweep, controller ends with no acknowledge
        for (int i = 0; i < DEPTH; i++) begin
            bus_start();
            send_byte({DEV, 1'b1}, ack); check("R3", 32'(ack), 1, "read address ack");
            send_byte(8'(i), ack);       check("R4", 32'(ack), 1, "read location ack");
            recv_byte(1'b0, v);
            check("R6", 32'(v), 32'(model[i]), "read data");
            bus_stop();
        end

        // R4: location beyond depth wraps
        e0 = evt_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'd19, ack); check("R4", 32'(ack), 1, "location 19 ack");
        send_byte(8'hA5, ack);
        bus_stop();
        model[3] = 8'hA5;
        check("R4", 32'(evt_idx), 3, "location 19 maps to entry 3");
        usr_read(3, v);
        check("R4", 32'(v), 32'hA5, "entry 3 after wrapped write");
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        send_byte(8'd35, ack);
        recv_byte(1'b0, v);
        check("R4", 32'(v), 32'hA5, "read location 35 maps to entry 3");
        bus_stop();

        // R7: sequential read across the last entry, then no acknowledge
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        send_byte(8'd14, ack);
        recv_byte(1'b1, v); check("R7", 32'(v), 32'(model[14]), "seq read 14");
        recv_byte(1'b1, v); check("R7", 32'(v), 32'(model[15]), "seq read 15");
        recv_byte(1'b1, v); check("R7", 32'(v), 32'(model[0]),  "seq read wraps to 0");
        recv_byte(1'b0, v); check("R7", 32'(v), 32'(model[1]),  "seq read 1");
        recv_byte(1'b0, v); check("R7", 32'(v), 32'hFF, "released after no acknowledge");
        bus_stop();

        // R3: addresses one bit away from DEV are ignored
        for (int k = 0; k < 7; k++) begin
            e0 = evt_cnt;
            h0 = oe_hi;
            bus_start();
            send_byte({DEV ^ 7'(1 << k), 1'b0}, ack);
            check("R3", 32'(ack), 0, "mismatched address not acked");
            send_byte(8'd2, ack);   check("R3", 32'(ack), 0, "no ack after mismatch");
            send_byte(8'h5A, ack);  check("R3", 32'(ack), 0, "no data ack after mismatch");
            bus_stop();
            check("R3", 32'(evt_cnt - e0), 0, "no store after mismatch");
            check("R3", 32'(oe_hi - h0), 0, "line never pulled after mismatch");
        end
        usr_read(2, v);
        check("R3", 32'(v), 32'(model[2]), "entry 2 untouched by mismatches");

        // R5: a second write byte is neither acked nor stored
        e0 = evt_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'd5, ack);
        send_byte(8'h3C, ack); check("R5", 32'(ack), 1, "first byte acked");
        send_byte(8'h77, ack); check("R5", 32'(ack), 0, "extra byte not acked");
        bus_stop();
        model[5] = 8'h3C;
        check("R5", 32'(evt_cnt - e0), 1, "single store");
        usr_read(5, v); check("R5", 32'(v), 32'h3C, "entry 5");
        usr_read(6, v); check("R5", 32'(v), 32'(model[6]), "entry 6 untouched");

        // R1: restart inside the address byte
        e0 = evt_cnt;
        bus_start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte({DEV, 1'b0}, ack); check("R1", 32'(ack), 1, "address after restart");
        send_byte(8'd9, ack);
        send_byte(8'h5E, ack);
        bus_stop();
        model[9] = 8'h5E;
        check("R1", 32'(evt_cnt - e0), 1, "write after restart");
        usr_read(9, v); check("R1", 32'(v), 32'h5E, "entry 9 after restart");

        // R1: restart inside a data byte aborts the write
        e0 = evt_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'd10, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte({DEV, 1'b1}, ack); check("R1", 32'(ack), 1, "read address after restart");
        send_byte(8'd10, ack);
        recv_byte(1'b0, v);
        check("R1", 32'(v), 32'(model[10]), "entry 10 unchanged by aborted write");
        bus_stop();
        check("R1", 32'(evt_cnt - e0), 0, "no store from aborted write");

        // R2: stop before data; next byte without start is ignored
        e0 = evt_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'd2, ack);
        bus_stop();
        scl_m = 1'b0; tick(Q);
        send_byte({DEV, 1'b0}, ack);
        check("R2", 32'(ack), 0, "byte after stop without start not acked");
        send_byte(8'h11, ack);
        check("R2", 32'(ack), 0, "second byte after stop not acked");
        scl_m = 1'b1; tick(Q);
        bus_stop();
        check("R2", 32'(evt_cnt - e0), 0, "no store after stop");
        check("R2", 32'(dut_oe), 0, "line released when idle");

        // R8 R10: strobe width and enable timing over the whole run
        check("R8", 32'(evt_long), 0, "strobe longer than one cycle");
        check("R10", 32'(oe_bad), 0, "enable changed while clock high");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule